// File: doc/BRIEF.md
# Flow-Through Byte-Write Memory Core

This block is a small synchronous word memory for a burst-capable memory subsystem. Each word is 36 bits wide and made of four 9-bit lanes, each lane holding eight data bits and one parity bit. An address sequencer outside this block supplies a registered word address and an "access active" select flag every cycle. The core turns a global-write strobe, a byte-write gate and four per-lane enables, all active low, into a per-lane write mask. The addressed word is written at the rising clock edge.

Reads are flow-through. The stored word at the presented address appears on the read-data port in the same cycle, with no output register. A drive-enable flag stands in for a tri-state pin driver, so the block can be synthesized. The flag is high only when:
- the access is selected,
- the active-low output enable is asserted (it acts combinationally),
- no write is happening in this cycle,
- sleep is off.

Sleep freezes the array and turns the drive flag off. Stored contents are kept through sleep and through reset.

Top module: `fbw_mem_core`

## Requirements
- R1: With `sel_i`=1, `sleep_i`=0 and `rst_n`=1, `wr_all_n_i`=0 writes all four lanes of `wdata_i` to `adr_i` at the clock edge. This happens whatever the values of `bw_gate_n_i` and `byte_en_n_i`.
- R2: With `wr_all_n_i`=1 and `bw_gate_n_i`=0, each low bit k of `byte_en_n_i` writes lane k, and any combination of lanes may be written in one cycle. Lane k is data bits `8k+7..8k` plus parity bit `32+k` of the word.
- R3: With `wr_all_n_i`=1 and `bw_gate_n_i`=1, no lane is written, whatever the value of `byte_en_n_i`.
- R4: `rdata_o` equals the stored word at `adr_i` in the same cycle. A word written at an edge is returned from the next cycle on.
- R5: `drive_o` is 1 exactly when `sel_i`=1, `oe_n_i`=0, `sleep_i`=0, `rst_n`=1 and no write is active. It follows `oe_n_i` within the cycle, without waiting for a clock edge.
- R6: In any cycle that writes at least one lane, `drive_o` is 0.
- R7: In a cycle with `sel_i`=0, `drive_o` is 0 in that same cycle and nothing is written.
- R8: While `sleep_i`=1, nothing is written and `drive_o` is 0. Contents stored before sleep read back unchanged afterwards.
- R9: While `rst_n`=0, nothing is written and `drive_o` is 0. Reset does not clear stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes and output drive |
| sel_i | input | 1 | Access active this cycle, from the address sequencer |
| oe_n_i | input | 1 | Active-low output enable, combinational |
| sleep_i | input | 1 | Sleep: freeze the array, turn the drive flag off |
| wr_all_n_i | input | 1 | Active-low global write of all lanes |
| bw_gate_n_i | input | 1 | Active-low gate for the per-lane enables |
| byte_en_n_i | input | 4 | Active-low per-lane write enables |
| adr_i | input | 6 | Registered word address |
| wdata_i | input | 36 | Write word: data in bits 31..0, parity in bits 35..32 |
| rdata_o | output | 36 | Flow-through read word at `adr_i` |
| drive_o | output | 1 | High when the read word should be driven out |

## Verification
Assertions check on every cycle that the drive flag is off when output enable is high, when the access is deselected, in sleep, and in any write cycle. They also check that a global write lands by the next cycle. Further assertions check that the word at an unchanged address stays the same after a cycle that was deselected, asleep, or had its lane enables gated off. Only the bench scenarios show the following:
- the exact lane and parity-bit mapping of byte writes;
- the drive flag changing when output enable moves within a cycle, with no clock edge;
- stored contents surviving sleep and a reset pulse.

// File: rtl/fbw_pkg.sv
// Package: shared constants and types for the flow-through byte-write core.
// Assumes the lane layout is data bytes packed low, parity bits packed high.
package fbw_pkg;
    localparam int LANES_DEF = 4;
    localparam int LANE_DATA_DEF = 8;
    localparam int DEPTH_DEF = 64;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_ALL   = 2'd1,
        WR_LANES = 2'd2
    } wr_kind_e;
endpackage

// File: rtl/fbw_wr_decode.sv
// Module: turns global write, lane gate and lane enables into a lane mask.
// Assumes all controls are active low and sampled by the caller's clock.
// Priority: global write first, then gated lane enables.
module fbw_wr_decode
    import fbw_pkg::*;
#(
    parameter int LANES = LANES_DEF
) (
    input  logic             wr_all_n,
    input  logic             gate_n,
    input  logic [LANES-1:0] en_n,
    output logic [LANES-1:0] mask,
    output logic             wr_any
);
    wr_kind_e kind;

    // Classify the requested write kind by priority.
    always_comb begin
        if (!wr_all_n)
            kind = WR_ALL;
        else if (!gate_n && (en_n != {LANES{1'b1}}))
            kind = WR_LANES;
        else
            kind = WR_NONE;
    end

    // Expand the kind into a per-lane write mask.
    always_comb begin
        unique case (kind)
            WR_ALL:   mask = {LANES{1'b1}};
            WR_LANES: mask = ~en_n;
            default:  mask = '0;
        endcase
    end

    assign wr_any = (kind != WR_NONE);
endmodule

// File: rtl/fbw_lane_array.sv
// Module: lane-split storage with a combinational (flow-through) read.
// Assumes DEPTH is a power of two; storage is not reset by design.
// Lane g holds data bits [g*LDW +: LDW] and parity bit PAR_BASE+g.
module fbw_lane_array #(
    parameter int DEPTH = 64,
    parameter int LANES = 4,
    parameter int LDW   = 8,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int LANE_W   = LDW + 1,
    localparam int PAR_BASE = LANES * LDW,
    localparam int WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [LANES-1:0]  mask,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lane_wr;
        logic [LANE_W-1:0] lane_rd;

        assign lane_wr = {wdata[PAR_BASE+g], wdata[g*LDW +: LDW]};

        // Store this lane at the clock edge when its mask bit is set.
        always_ff @(posedge clk) begin
            if (we && mask[g])
                mem[adr] <= lane_wr;
        end

        assign lane_rd = mem[adr];
        assign rdata[g*LDW +: LDW] = lane_rd[LDW-1:0];
        assign rdata[PAR_BASE+g]   = lane_rd[LDW];
    end
endmodule

// File: rtl/fbw_drive_ctl.sv
// Module: output drive qualification and array write qualification.
// Assumes oe_n is asynchronous and passes through combinational logic only.
module fbw_drive_ctl (
    input  logic rst_n,
    input  logic sel,
    input  logic oe_n,
    input  logic sleep,
    input  logic wr_any,
    output logic arr_we,
    output logic drive
);
    logic awake;

    // Block is live only out of reset and out of sleep.
    assign awake  = rst_n && !sleep;
    // Array write needs a live, selected access with a write requested.
    assign arr_we = awake && sel && wr_any;
    // Drive only for a live, selected, non-write access with OE asserted.
    assign drive  = awake && sel && !oe_n && !wr_any;
endmodule

// File: rtl/fbw_mem_core_chk.sv
// Module: property checker bound to fbw_mem_core.
// Assumes reset is synchronous active low; all checks are off during reset.
module fbw_mem_core_chk #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              oe_n_i,
    input logic              sleep_i,
    input logic              wr_all_n_i,
    input logic              bw_gate_n_i,
    input logic [LANES-1:0]  byte_en_n_i,
    input logic [ADDR_W-1:0] adr_i,
    input logic [WORD_W-1:0] wdata_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic              drive_o
);
    // R1: a global write is visible at the same address one cycle later.
    a_r1_full_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !sleep_i && !wr_all_n_i) ##1 $stable(adr_i) |-> rdata_o == $past(wdata_i));

    // R3: gated-off lane enables leave the word untouched.
    a_r3_gated_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_all_n_i && bw_gate_n_i) ##1 $stable(adr_i) |-> $stable(rdata_o));

    // R5: output enable high keeps the drive flag off.
    a_r5_oe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drive_o);

    // R6: a selected write cycle never drives.
    a_r6_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && (!wr_all_n_i || (!bw_gate_n_i && !(&byte_en_n_i)))) |-> !drive_o);

    // R7: deselect turns drive off in that same cycle.
    a_r7_deselect_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> !drive_o);

    // R7: a deselected cycle writes nothing.
    a_r7_deselect_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i ##1 $stable(adr_i) |-> $stable(rdata_o));

    // R8: sleep keeps drive off.
    a_r8_sleep_blank: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !drive_o);

    // R8: sleep freezes the array.
    a_r8_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i ##1 $stable(adr_i) |-> $stable(rdata_o));
endmodule

bind fbw_mem_core fbw_mem_core_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .oe_n_i(oe_n_i),
    .sleep_i(sleep_i), .wr_all_n_i(wr_all_n_i), .bw_gate_n_i(bw_gate_n_i),
    .byte_en_n_i(byte_en_n_i), .adr_i(adr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
);

// File: rtl/fbw_mem_core.sv
// Module: flow-through byte-write memory core (top).
// Assumes adr_i and sel_i come already registered from an address sequencer.
// The drive flag replaces a tri-state pin driver.
module fbw_mem_core
    import fbw_pkg::*;
#(
    parameter int DEPTH     = DEPTH_DEF,
    parameter int LANES     = LANES_DEF,
    parameter int LANE_DATA = LANE_DATA_DEF,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = LANES * (LANE_DATA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    input  logic              wr_all_n_i,
    input  logic              bw_gate_n_i,
    input  logic [LANES-1:0]  byte_en_n_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              drive_o
);
    logic [LANES-1:0] lane_mask;
    logic             wr_any;
    logic             arr_we;

    fbw_wr_decode #(.LANES(LANES)) u_dec (
        .wr_all_n (wr_all_n_i),
        .gate_n   (bw_gate_n_i),
        .en_n     (byte_en_n_i),
        .mask     (lane_mask),
        .wr_any   (wr_any)
    );

    fbw_drive_ctl u_drv (
        .rst_n  (rst_n),
        .sel    (sel_i),
        .oe_n   (oe_n_i),
        .sleep  (sleep_i),
        .wr_any (wr_any),
        .arr_we (arr_we),
        .drive  (drive_o)
    );

    fbw_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LDW(LANE_DATA)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .adr   (adr_i),
        .mask  (lane_mask),
        .wdata (wdata_i),
        .rdata (rdata_o)
    );
endmodule

// File: tb/fbw_mem_core_bench.sv
// Bench: behavioural reference model compared against the core every cycle.
module fbw_mem_core_bench;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n, sel, oe_n, slp, wall_n, gate_n;
    logic [3:0]  en_n;
    logic [AW-1:0] adr;
    logic [35:0] wd;
    logic [35:0] rdata;
    logic        drive;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [35:0] model [DEPTH];

    always #4 clk = ~clk;

    fbw_mem_core u_fbw_mem_core (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .oe_n_i(oe_n), .sleep_i(slp),
        .wr_all_n_i(wall_n), .bw_gate_n_i(gate_n), .byte_en_n_i(en_n),
        .adr_i(adr), .wdata_i(wd), .rdata_o(rdata), .drive_o(drive)
    );

    function automatic logic [3:0] model_mask();
        if (wall_n == 1'b0) return 4'hF;
        if (gate_n == 1'b0) return ~en_n;
        return 4'h0;
    endfunction

    function automatic bit model_write();
        return rst_n && sel && !slp && (model_mask() != 4'h0);
    endfunction

    function automatic logic [35:0] pat(int a);
        logic [35:0] w;
        w[31:0]  = 32'h1000_0000 + a * 32'h0101_0101;
        w[35:32] = 4'(a) ^ 4'hA;
        return w;
    endfunction

    task automatic compare(string req);
        logic exp_drv;
        exp_drv = rst_n && sel && !oe_n && !slp && !model_write();
        checks++;
        if (drive !== exp_drv) begin
            fails++;
            $display("FAIL %s drive_o actual=%b expected=%b", req, drive, exp_drv);
        end
        checks++;
        if (rdata !== model[adr]) begin
            fails++;
            $display("FAIL %s rdata_o adr=%0d actual=%h expected=%h", req, adr, rdata, model[adr]);
        end
    endtask

    // One cycle: apply inputs, compare mid-cycle, then step the model at the edge.
    task automatic op(string req, logic s, logic o, logic sl, logic wa, logic g,
                      logic [3:0] e, int a, logic [35:0] d);
        sel = s; oe_n = o; slp = sl; wall_n = wa; gate_n = g;
        en_n = e; adr = AW'(a); wd = d;
        #2;
        compare(req);
        @(posedge clk);
        if (model_write()) begin
            logic [3:0] m;
            m = model_mask();
            for (int k = 0; k < 4; k++) begin
                if (m[k]) begin
                    model[adr][k*8 +: 8] = wd[k*8 +: 8];
                    model[adr][32+k]     = wd[32+k];
                end
            end
        end
        #2;
    endtask

    task automatic rd(string req, int a);
        op(req, 1, 0, 0, 1, 1, 4'hF, a, 36'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 'x;
        rst_n = 0; sel = 0; oe_n = 1; slp = 0; wall_n = 1; gate_n = 1;
        en_n = 4'hF; adr = '0; wd = '0;
        @(posedge clk); #2;
        // R9: reset state, drive off with a write attempted.
        for (int i = 0; i < 3; i++) op("R9", 1, 0, 0, 0, 1, 4'hF, 3, 36'h123456789);
        rst_n = 1;

        // R1: global write overrides gate and lane enables; R6 drive off meanwhile.
        for (int a = 0; a < DEPTH; a++) op("R1", 1, 0, 0, 0, 0, 4'b0101, a, pat(a));
        // R4: flow-through read of every word, including the top address.
        for (int a = 0; a < DEPTH; a++) rd("R4", a);
        op("R4", 1, 0, 0, 0, 1, 4'hF, DEPTH-1, 36'hF_FFFF_FFFF);
        rd("R4", DEPTH-1);
        op("R4", 1, 0, 0, 0, 1, 4'hF, 7, 36'h5_DEAD_BEEF);
        rd("R4", 7);

        // R2: single lanes, then combinations including parity bits.
        for (int k = 0; k < 4; k++) begin
            op("R2", 1, 0, 0, 1, 1, 4'hF, 10, 36'h0);
            op("R2", 1, 0, 0, 0, 1, 4'hF, 10, 36'h0);
            op("R2", 1, 1, 0, 1, 0, ~(4'b1 << k), 10, 36'hF_FFFF_FFFF);
            rd("R2", 10);
        end
        op("R2", 1, 0, 0, 1, 0, 4'b1001, 11, 36'h6_1234_5678);
        rd("R2", 11);
        op("R2", 1, 0, 0, 1, 0, 4'b0000, 12, 36'h9_CAFE_F00D);
        rd("R2", 12);

        // R3: gate high blocks lane enables.
        op("R3", 1, 0, 0, 1, 1, 4'b0000, 12, 36'h0);
        rd("R3", 12);

        // R6: selected byte write with OE low still does not drive.
        op("R6", 1, 0, 0, 1, 0, 4'b1110, 13, 36'h1_0000_00AA);
        rd("R6", 13);

        // R5: OE high blocks drive; OE acts within the cycle.
        op("R5", 1, 1, 0, 1, 1, 4'hF, 13, 36'h0);
        sel = 1; oe_n = 0; slp = 0; wall_n = 1; gate_n = 1; en_n = 4'hF; adr = 13;
        #1;
        checks++;
        if (drive !== 1'b1) begin
            fails++;
            $display("FAIL R5 drive_o async on actual=%b expected=1", drive);
        end
        oe_n = 1; #1;
        checks++;
        if (drive !== 1'b0) begin
            fails++;
            $display("FAIL R5 drive_o async off actual=%b expected=0", drive);
        end
        oe_n = 0; #1;
        checks++;
        if (drive !== 1'b1) begin
            fails++;
            $display("FAIL R5 drive_o async back on actual=%b expected=1", drive);
        end
        @(posedge clk); #2;

        // R7: deselect turns drive off that cycle and blocks writes.
        rd("R7", 20);
        op("R7", 0, 0, 0, 0, 0, 4'h0, 20, 36'h0);
        rd("R7", 20);

        // R8: sleep blocks writes and drive; contents kept.
        for (int i = 0; i < 4; i++) op("R8", 1, 0, 1, 0, 0, 4'h0, 21, 36'h7_7777_7777);
        rd("R8", 21);

        // R9: reset pulse blocks writes and keeps contents.
        rst_n = 0;
        op("R9", 1, 0, 0, 0, 1, 4'hF, 22, 36'h0);
        rst_n = 1;
        rd("R9", 22);
        rd("R9", 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule